// File: doc/BRIEF.md
# Substream ID Validator

This block checks the substream identifier that may accompany an incoming transaction once the stream's configuration is known. It takes the per-stream settings (whether stage 1 translation is enabled, the log2 size of the context descriptor table and a two-bit default-substream mode) together with the transaction's substream flag, its substream value, its address and the stage 1 input address size in bits. From these it picks one of three verdicts: proceed to a context descriptor fetch at a given index, skip stage 1 and go straight to stage 2, or fault with an event code.

For address translation requests from an endpoint, the block also gives the response class that a fault maps to. Configuration faults give a completer-abort denial. An out-of-range address on the stage 1 bypass path gives a successful completion with no read or write access. Ordinary transactions that fault are terminated with an abort. The decision is made combinationally, and every result appears one clock after the request through a single output register stage.

Top module: `ssid_check`

## Requirements
- R1: With stage 1 disabled and a substream ID present, the verdict is fault (2) with event bad-substream (1).
- R2: With stage 1 disabled and no substream ID, the verdict is skip-stage-1 (1) with event none (0), subject to R8.
- R3: With stage 1 enabled, a substream ID present and a table size field of 0, the verdict is fault with event bad-substream.
- R4: With stage 1 enabled and a substream ID present, an ID at or above 2^size gives fault with bad-substream. Otherwise the verdict is proceed (0) with index equal to the ID, subject to R5.
- R5: With default mode 2'b10, an in-range substream ID of 0 gives fault with event stream-disabled (2).
- R6: With stage 1 enabled, no substream ID and a non-zero size, the outcome depends on the default mode. Modes 2'b00 and 2'b11 give fault with stream-disabled. Mode 2'b01 gives skip-stage-1, subject to R8. Mode 2'b10 gives proceed with index 0.
- R7: With stage 1 enabled, no substream ID and a size of 0, the verdict is proceed with index 0 in every default mode.
- R8: On every skip-stage-1 path, an address with any bit set at or above bit position ias gives fault with event address-size (3) instead of the skip.
- R9: The response field is encoded as 0 pass, 1 terminate, 2 deny-CA and 3 complete-no-access. A faulting ordinary transaction gets 1. A faulting translation request gets 3 for address-size and 2 otherwise. Any transaction that does not fault gets 0. The index is 0 unless the verdict is proceed.
- R10: outValid rises exactly one cycle after inValid and is 0 after reset. The other outputs are 0 whenever outValid has been low since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request valid |
| isTr | input | 1 | Request is an address translation request |
| ssidPresent | input | 1 | Substream ID accompanies the request |
| ssid | input | SSID_W | Substream ID value |
| s1Enable | input | 1 | Stage 1 translates for this stream |
| cdMax | input | CDMAX_W | log2 of the descriptor table size |
| dfltMode | input | 2 | Default-substream mode |
| addr | input | ADDR_W | Input address |
| ias | input | IAS_W | Input address size in bits |
| outValid | output | 1 | Result valid |
| verdict | output | 2 | 0 proceed, 1 skip stage 1, 2 fault |
| cdIndex | output | SSID_W | Descriptor index when proceeding |
| eventCode | output | 2 | 0 none, 1 bad substream, 2 stream disabled, 3 address size |
| atsResp | output | 2 | Response class (R9) |

## Verification
The default-mode skip (R6, mode 2'b01) and the address-size check (R8) resolve in the same cycle, because a skip is only reported when the address passes. The bench provokes this with no substream ID, a non-zero size and mode 01. It places the address just below 2^ias and at exactly 2^ias, and also drives translation requests through the same path. It then expects a skip for the first address and an address-size fault with a no-access response for the second. Random traffic with mixed ias values then covers the same overlap broadly.

// File: rtl/ssid_check_pkg.sv
package ssid_check_pkg;

  typedef enum logic [1:0] {
    VERD_PROCEED = 2'd0,
    VERD_SKIP_S1 = 2'd1,
    VERD_FAULT   = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    EVT_NONE       = 2'd0,
    EVT_BAD_SUBSTR = 2'd1,
    EVT_STREAM_OFF = 2'd2,
    EVT_ADDR_SIZE  = 2'd3
  } event_e;

  typedef enum logic [1:0] {
    RESP_PASS      = 2'd0,
    RESP_TERMINATE = 2'd1,
    RESP_DENY_CA   = 2'd2,
    RESP_NO_ACCESS = 2'd3
  } resp_e;

  localparam logic [1:0] MODE_DISABLE = 2'b00;
  localparam logic [1:0] MODE_BYPASS  = 2'b01;
  localparam logic [1:0] MODE_ENTRY0  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic   takeFault;
    logic   takeSkip;
    logic   takeProceed;
    logic   entryZero;
    event_e evt;
  } strobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic ssidOutOfRange;
    logic ssidZero;
    logic cdMaxZero;
    logic addrTooBig;
  } cond_t;

endpackage

// File: rtl/ssid_check_ctrl.sv
module ssid_check_ctrl
  import ssid_check_pkg::*;
(
  input  logic       ssidPresent,
  input  logic       s1Enable,
  input  logic [1:0] dfltMode,
  input  cond_t      cond,
  output strobe_t    strobe
);

  strobe_t skipOrSize;

  // shared stage-1 bypass outcome: address check decides skip vs fault
  always_comb begin
    skipOrSize = '0;
    if (cond.addrTooBig) begin
      skipOrSize.takeFault = 1'b1;
      skipOrSize.evt       = EVT_ADDR_SIZE;
    end else begin
      skipOrSize.takeSkip  = 1'b1;
      skipOrSize.evt       = EVT_NONE;
    end
  end

  always_comb begin
    strobe = '0;
    strobe.evt = EVT_NONE;
    if (!s1Enable) begin
      if (ssidPresent) begin
        strobe.takeFault = 1'b1;
        strobe.evt       = EVT_BAD_SUBSTR;
      end else begin
        strobe = skipOrSize;
      end
    end else if (ssidPresent) begin
      if (cond.cdMaxZero || cond.ssidOutOfRange) begin
        strobe.takeFault = 1'b1;
        strobe.evt       = EVT_BAD_SUBSTR;
      end else if (dfltMode == MODE_ENTRY0 && cond.ssidZero) begin
        strobe.takeFault = 1'b1;
        strobe.evt       = EVT_STREAM_OFF;
      end else begin
        strobe.takeProceed = 1'b1;
      end
    end else if (cond.cdMaxZero) begin
      strobe.takeProceed = 1'b1;
      strobe.entryZero   = 1'b1;
    end else begin
      unique case (dfltMode)
        MODE_BYPASS: strobe = skipOrSize;
        MODE_ENTRY0: begin
          strobe.takeProceed = 1'b1;
          strobe.entryZero   = 1'b1;
        end
        // MODE_DISABLE and the reserved value 2'b11
        default: begin
          strobe.takeFault = 1'b1;
          strobe.evt       = EVT_STREAM_OFF;
        end
      endcase
    end
  end

endmodule

// File: rtl/ssid_check_dp.sv
module ssid_check_dp
  import ssid_check_pkg::*;
#(
  parameter int SSID_W  = 20,
  parameter int ADDR_W  = 48,
  parameter int CDMAX_W = 5,
  parameter int IAS_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic               isTr,
  input  logic [SSID_W-1:0]  ssid,
  input  logic [CDMAX_W-1:0] cdMax,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [IAS_W-1:0]   ias,
  input  strobe_t            strobe,
  output cond_t              cond,
  output logic               outValid,
  output logic [1:0]         verdict,
  output logic [SSID_W-1:0]  cdIndex,
  output logic [1:0]         eventCode,
  output logic [1:0]         atsResp
);

  localparam logic [SSID_W-1:0] IDX_ZERO = '0;

  logic [SSID_W-1:0] ssidHigh;
  logic [ADDR_W-1:0] addrHigh;

  // shifts past the width yield zero, so oversized sizes never fault
  assign ssidHigh = ssid >> cdMax;
  assign addrHigh = addr >> ias;

  assign cond.ssidOutOfRange = |ssidHigh;
  assign cond.ssidZero       = ~|ssid;
  assign cond.cdMaxZero      = ~|cdMax;
  assign cond.addrTooBig     = |addrHigh;

  verdict_e          verdNext;
  resp_e             respNext;
  logic [SSID_W-1:0] idxNext;

  always_comb begin
    verdNext = VERD_PROCEED;
    if (strobe.takeFault)     verdNext = VERD_FAULT;
    else if (strobe.takeSkip) verdNext = VERD_SKIP_S1;
  end

  always_comb begin
    idxNext = IDX_ZERO;
    if (strobe.takeProceed && !strobe.entryZero) idxNext = ssid;
  end

  always_comb begin
    respNext = RESP_PASS;
    if (strobe.takeFault) begin
      if (!isTr)                         respNext = RESP_TERMINATE;
      else if (strobe.evt == EVT_ADDR_SIZE) respNext = RESP_NO_ACCESS;
      else                               respNext = RESP_DENY_CA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      verdict   <= 2'd0;
      cdIndex   <= '0;
      eventCode <= 2'd0;
      atsResp   <= 2'd0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        verdict   <= verdNext;
        cdIndex   <= idxNext;
        eventCode <= strobe.evt;
        atsResp   <= respNext;
      end
    end
  end

endmodule

// File: rtl/ssid_check.sv
module ssid_check
  import ssid_check_pkg::*;
#(
  parameter int SSID_W  = 20,
  parameter int ADDR_W  = 48,
  parameter int CDMAX_W = 5,
  parameter int IAS_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic               isTr,
  input  logic               ssidPresent,
  input  logic [SSID_W-1:0]  ssid,
  input  logic               s1Enable,
  input  logic [CDMAX_W-1:0] cdMax,
  input  logic [1:0]         dfltMode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [IAS_W-1:0]   ias,
  output logic               outValid,
  output logic [1:0]         verdict,
  output logic [SSID_W-1:0]  cdIndex,
  output logic [1:0]         eventCode,
  output logic [1:0]         atsResp
);

  cond_t   cond;
  strobe_t strobe;

  ssid_check_ctrl u_ctrl (
    .ssidPresent (ssidPresent),
    .s1Enable    (s1Enable),
    .dfltMode    (dfltMode),
    .cond        (cond),
    .strobe      (strobe)
  );

  ssid_check_dp #(
    .SSID_W  (SSID_W),
    .ADDR_W  (ADDR_W),
    .CDMAX_W (CDMAX_W),
    .IAS_W   (IAS_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .isTr      (isTr),
    .ssid      (ssid),
    .cdMax     (cdMax),
    .addr      (addr),
    .ias       (ias),
    .strobe    (strobe),
    .cond      (cond),
    .outValid  (outValid),
    .verdict   (verdict),
    .cdIndex   (cdIndex),
    .eventCode (eventCode),
    .atsResp   (atsResp)
  );

endmodule

// File: rtl/ssid_check_chk.sv
module ssid_check_chk #(
  parameter int SSID_W  = 20,
  parameter int ADDR_W  = 48,
  parameter int CDMAX_W = 5,
  parameter int IAS_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               isTr,
  input logic               ssidPresent,
  input logic [SSID_W-1:0]  ssid,
  input logic               s1Enable,
  input logic [CDMAX_W-1:0] cdMax,
  input logic [1:0]         dfltMode,
  input logic [ADDR_W-1:0]  addr,
  input logic [IAS_W-1:0]   ias,
  input logic               outValid,
  input logic [1:0]         verdict,
  input logic [SSID_W-1:0]  cdIndex,
  input logic [1:0]         eventCode,
  input logic [1:0]         atsResp
);

  a_r1_nos1_with_ssid: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !s1Enable && ssidPresent |=> verdict == 2'd2 && eventCode == 2'd1);

  a_r3_table_off: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && s1Enable && ssidPresent && cdMax == '0 |=> verdict == 2'd2 && eventCode == 2'd1);

  a_r4_in_range_index: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && s1Enable && ssidPresent && cdMax != '0 && ssid != '0 && (ssid >> cdMax) == '0
    |=> verdict == 2'd0 && cdIndex == $past(ssid));

  a_r6_entry0_mode: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && s1Enable && !ssidPresent && cdMax != '0 && dfltMode == 2'b10
    |=> verdict == 2'd0 && cdIndex == '0);

  a_r7_small_table: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && s1Enable && !ssidPresent && cdMax == '0 |=> verdict == 2'd0 && cdIndex == '0);

  a_r8_bypass_addr: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !s1Enable && !ssidPresent && (addr >> ias) != '0
    |=> verdict == 2'd2 && eventCode == 2'd3);

  a_r9_ordinary_fault: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !isTr |=> (verdict == 2'd2) == (atsResp == 2'd1));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == $past(inValid));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid && !$past(outValid) && !$past(inValid) |-> $stable(verdict) && $stable(atsResp));

endmodule

bind ssid_check ssid_check_chk #(
  .SSID_W (SSID_W), .ADDR_W (ADDR_W), .CDMAX_W (CDMAX_W), .IAS_W (IAS_W)
) u_chk (
  .clk (clk), .rst_n (rst_n), .inValid (inValid), .isTr (isTr),
  .ssidPresent (ssidPresent), .ssid (ssid), .s1Enable (s1Enable),
  .cdMax (cdMax), .dfltMode (dfltMode), .addr (addr), .ias (ias),
  .outValid (outValid), .verdict (verdict), .cdIndex (cdIndex),
  .eventCode (eventCode), .atsResp (atsResp)
);

// File: tb/ssid_check_tb.sv
module ssid_check_tb;

  localparam int SSID_W  = 20;
  localparam int ADDR_W  = 48;
  localparam int CDMAX_W = 5;
  localparam int IAS_W   = 7;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               inValid = 1'b0;
  logic               isTr = 1'b0;
  logic               ssidPresent = 1'b0;
  logic [SSID_W-1:0]  ssid = '0;
  logic               s1Enable = 1'b0;
  logic [CDMAX_W-1:0] cdMax = '0;
  logic [1:0]         dfltMode = 2'b00;
  logic [ADDR_W-1:0]  addr = '0;
  logic [IAS_W-1:0]   ias = '0;
  logic               outValid;
  logic [1:0]         verdict;
  logic [SSID_W-1:0]  cdIndex;
  logic [1:0]         eventCode;
  logic [1:0]         atsResp;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ssid_check #(.SSID_W(SSID_W), .ADDR_W(ADDR_W), .CDMAX_W(CDMAX_W), .IAS_W(IAS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .isTr(isTr),
    .ssidPresent(ssidPresent), .ssid(ssid), .s1Enable(s1Enable), .cdMax(cdMax),
    .dfltMode(dfltMode), .addr(addr), .ias(ias), .outValid(outValid),
    .verdict(verdict), .cdIndex(cdIndex), .eventCode(eventCode), .atsResp(atsResp)
  );

  // expected {verdict, event, resp, index}
  function automatic logic [SSID_W+5:0] model(
    input logic tr, input logic pres, input logic [SSID_W-1:0] id, input logic s1,
    input logic [CDMAX_W-1:0] mx, input logic [1:0] md,
    input logic [ADDR_W-1:0] a, input logic [IAS_W-1:0] sz);
    int v, e, r;
    logic [SSID_W-1:0] ix;
    logic big, oob, skipReq;
    v = 0; e = 0; ix = '0; skipReq = 1'b0;
    big = 1'b0;
    for (int b = 0; b < ADDR_W; b++) if (b >= int'(sz) && a[b]) big = 1'b1;
    oob = 1'b0;
    for (int b = 0; b < SSID_W; b++) if (b >= int'(mx) && id[b]) oob = 1'b1;
    if (!s1) begin
      if (pres) begin v = 2; e = 1; end else skipReq = 1'b1;            // R1 R2
    end else if (pres) begin
      if (mx == 0 || oob) begin v = 2; e = 1; end                       // R3 R4
      else if (md == 2'b10 && id == 0) begin v = 2; e = 2; end          // R5
      else begin v = 0; ix = id; end
    end else if (mx == 0) begin v = 0; end                              // R7
    else if (md == 2'b01) skipReq = 1'b1;                               // R6
    else if (md == 2'b10) v = 0;
    else begin v = 2; e = 2; end
    if (skipReq) begin
      if (big) begin v = 2; e = 3; end else v = 1;                      // R8
    end
    if (v != 2) r = 0;                                                  // R9
    else if (!tr) r = 1;
    else if (e == 3) r = 3;
    else r = 2;
    return {v[1:0], e[1:0], r[1:0], ix};
  endfunction

  task automatic checkOne(input string tag, input logic [SSID_W+5:0] got, input logic [SSID_W+5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got v=%0d e=%0d r=%0d idx=%0d exp v=%0d e=%0d r=%0d idx=%0d", tag,
               got[SSID_W+5:SSID_W+4], got[SSID_W+3:SSID_W+2], got[SSID_W+1:SSID_W], got[SSID_W-1:0],
               exp[SSID_W+5:SSID_W+4], exp[SSID_W+3:SSID_W+2], exp[SSID_W+1:SSID_W], exp[SSID_W-1:0]);
    end
  endtask

  // drive at a falling edge, result registered at next rising edge, sample at next falling edge
  task automatic run(input string tag, input logic tr, input logic pres, input logic [SSID_W-1:0] id,
                     input logic s1, input logic [CDMAX_W-1:0] mx, input logic [1:0] md,
                     input logic [ADDR_W-1:0] a, input logic [IAS_W-1:0] sz);
    isTr = tr; ssidPresent = pres; ssid = id; s1Enable = s1; cdMax = mx;
    dfltMode = md; addr = a; ias = sz; inValid = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b1) begin
      fails++;
      $display("FAIL R10 outValid got %0b exp 1", outValid);
    end
    checkOne(tag, {verdict, eventCode, atsResp, cdIndex}, model(tr, pres, id, s1, mx, md, a, sz));
    inValid = 1'b0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    @(negedge clk);
    checks++;
    if ({outValid, verdict, eventCode, atsResp, cdIndex} !== '0) begin
      fails++;
      $display("FAIL R10 reset outputs got %0h exp 0", {outValid, verdict, eventCode, atsResp, cdIndex});
    end
    rst_n = 1'b1;
    @(negedge clk);

    run("R1 nos1 ssid", 1'b0, 1'b1, 20'd5, 1'b0, 5'd4, 2'b00, 48'h10, 7'd32);
    run("R1 tr nos1 ssid", 1'b1, 1'b1, 20'd5, 1'b0, 5'd4, 2'b00, 48'h10, 7'd32);
    run("R2 nos1 skip", 1'b0, 1'b0, 20'd0, 1'b0, 5'd4, 2'b00, 48'h10, 7'd32);
    run("R3 table off", 1'b1, 1'b1, 20'd0, 1'b1, 5'd0, 2'b01, 48'h0, 7'd32);
    run("R4 ssid at limit", 1'b1, 1'b1, 20'd16, 1'b1, 5'd4, 2'b00, 48'h0, 7'd32);
    run("R4 ssid below limit", 1'b0, 1'b1, 20'd15, 1'b1, 5'd4, 2'b00, 48'h0, 7'd32);
    run("R4 wide table", 1'b0, 1'b1, 20'hFFFFF, 1'b1, 5'd20, 2'b00, 48'h0, 7'd32);
    run("R5 ssid0 reserved", 1'b0, 1'b1, 20'd0, 1'b1, 5'd3, 2'b10, 48'h0, 7'd32);
    run("R5 ssid0 other mode", 1'b0, 1'b1, 20'd0, 1'b1, 5'd3, 2'b01, 48'h0, 7'd32);
    run("R6 mode00", 1'b1, 1'b0, 20'd0, 1'b1, 5'd3, 2'b00, 48'h0, 7'd32);
    run("R6 mode11", 1'b0, 1'b0, 20'd0, 1'b1, 5'd3, 2'b11, 48'h0, 7'd32);
    run("R6 mode10", 1'b0, 1'b0, 20'd9, 1'b1, 5'd3, 2'b10, 48'h0, 7'd32);
    run("R6 mode01 just below", 1'b1, 1'b0, 20'd0, 1'b1, 5'd3, 2'b01, 48'hFFFF_FFFF, 7'd32);
    run("R8 mode01 at size", 1'b1, 1'b0, 20'd0, 1'b1, 5'd3, 2'b01, 48'h1_0000_0000, 7'd32);
    run("R8 nos1 at size", 1'b0, 1'b0, 20'd0, 1'b0, 5'd3, 2'b00, 48'h1_0000_0000, 7'd32);
    run("R8 full width", 1'b0, 1'b0, 20'd0, 1'b0, 5'd3, 2'b00, 48'hFFFF_FFFF_FFFF, 7'd48);
    run("R7 mode00 small table", 1'b0, 1'b0, 20'd7, 1'b1, 5'd0, 2'b00, 48'h0, 7'd32);
    run("R7 mode01 small table", 1'b0, 1'b0, 20'd7, 1'b1, 5'd0, 2'b01, 48'hFFFF_FFFF_FFFF, 7'd20);

    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle outValid got %0b exp 0", outValid);
    end

    for (int n = 0; n < 400; n++) begin
      logic [SSID_W-1:0]  rid;
      logic [ADDR_W-1:0]  ra;
      logic [IAS_W-1:0]   rsz;
      logic [CDMAX_W-1:0] rmx;
      rid = SSID_W'($urandom) >> ($urandom % SSID_W);
      rmx = CDMAX_W'($urandom % 8);
      if ($urandom % 8 == 0) rmx = CDMAX_W'($urandom);
      rsz = IAS_W'(20 + $urandom % 29);
      ra  = {16'($urandom), 32'($urandom)} >> ($urandom % ADDR_W);
      run("R9 random", 1'($urandom), 1'($urandom), rid, 1'($urandom), rmx, 2'($urandom), ra, rsz);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule